// File: doc/BRIEF.md
# Out-of-Order Write Response Scheduler

This block sits on the receiving side of an AXI4 write path and keeps track of which write transactions are still waiting for an answer. Each accepted write address takes a tracker slot that records its ID and its position in arrival order. Write data is not interleaved, so data beats always belong to the oldest transaction whose data is not yet complete, whatever its ID. The beat flagged last closes that transaction's data.

A transaction whose data is complete may be answered on the B channel. The environment names the transaction it would like answered by giving its age rank on a select input, where rank 0 is the oldest outstanding transaction. The block honours that choice only when three conditions hold: the data is complete, the rank lies inside the reorder window, and no older transaction with the same ID is still outstanding. Otherwise it answers the oldest outstanding transaction, provided that transaction's data is complete. Responses can therefore leave in a different order from the addresses across IDs, but never within one ID.

Top module: `wresp_sched`

## Requirements
- R1: No more than SLOTS (default 4) transactions are outstanding, counted from address acceptance to the B handshake; `aw_ready` is low while all slots are taken.
- R2: `w_ready` is low when no accepted transaction is waiting for data and no address is being accepted in the same cycle.
- R3: A B response for a transaction appears only after the beat with `w_last` = 1 has been accepted for it; non-last beats never produce a response.
- R4: Two outstanding transactions with the same ID are answered in the order of their address acceptance.
- R5: When the transaction at rank `sel_age` is eligible, it is the one answered, even if older transactions with other IDs are still waiting.
- R6: Only transactions with rank below DEPTH (default 2) may be chosen out of order. Rank is the position among outstanding transactions in acceptance order, with 0 the oldest.
- R7: When the requested rank is not eligible, the transaction at rank 0 is answered as soon as its data is complete.
- R8: While `b_valid` is high and `b_ready` is low, `b_valid` and `b_id` hold their values. `b_resp` is always 2'b00 (OKAY).
- R9: An address and a last data beat for that same transaction are accepted in one cycle. `w_ready` is high in that cycle, and `b_valid` rises two clock edges after it.
- R10: After reset no slot is in use, `b_valid` is low, `aw_ready` is high and `w_ready` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address accepted when high with aw_valid |
| aw_id | input | ID_W | Transaction ID of the address |
| w_valid | input | 1 | Write data beat valid |
| w_ready | output | 1 | Write data beat accepted when high with w_valid |
| w_last | input | 1 | Beat closes the current transaction's data |
| sel_age | input | AGE_W | Age rank of the transaction the environment wants answered |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response taken when high with b_valid |
| b_id | output | ID_W | ID of the answered transaction |
| b_resp | output | 2 | Response code, always OKAY |

## Verification
A corrupted age rank or ID in a slot shows at the B port on the next answered transaction, either as a `b_id` that does not match the expected ID or as same-ID responses leaving in the wrong order. A lost data-complete flag stalls `b_valid`. A stuck valid bit shows as `aw_ready` staying low after four addresses, or as a missing response. The scoreboard predicts each response from the selection rules as soon as the previous one is taken. Because every slot is freed by a B handshake, a wrong internal state becomes visible within one response of the fault.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/wrs_free_find.sv
module wrs_free_find #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  busy,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/wrs_picker.sv
module wrs_picker #(
  parameter int N     = 4,
  parameter int IDW   = 4,
  parameter int AW    = 2,
  parameter int DEPTH = 2
) (
  input  logic [N-1:0]   vld,
  input  logic [N-1:0]   done,
  input  logic [IDW-1:0] ids  [N],
  input  logic [AW-1:0]  ages [N],
  input  logic [AW-1:0]  sel,
  output logic           ok,
  output logic [AW-1:0]  slot
);
  logic [N-1:0] elig;
  logic [N-1:0] older_same;
  logic         req_hit;
  logic [AW-1:0] req_slot;
  logic         old_hit;
  logic [AW-1:0] old_slot;

  generate
    for (genvar g = 0; g < N; g++) begin : g_elig
      always_comb begin
        older_same[g] = 1'b0;
        for (int j = 0; j < N; j++) begin
          if (j != g && vld[j] && ids[j] == ids[g] && ages[j] < ages[g])
            older_same[g] = 1'b1;
        end
        elig[g] = vld[g] && done[g] && (int'(ages[g]) < DEPTH) && !older_same[g];
      end
    end
  endgenerate

  always_comb begin
    req_hit  = 1'b0;
    req_slot = '0;
    old_hit  = 1'b0;
    old_slot = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && ages[i] == sel) begin
        req_hit  = 1'b1;
        req_slot = AW'(i);
      end
      if (elig[i] && (!old_hit || ages[i] < ages[old_slot])) begin
        old_hit  = 1'b1;
        old_slot = AW'(i);
      end
    end
    ok   = req_hit || old_hit;
    slot = req_hit ? req_slot : old_slot;
  end
endmodule

// File: rtl/wresp_sched.sv
module wresp_sched
  import wrs_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int ID_W  = 4,
  parameter int DEPTH = 2,
  localparam int AGE_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             aw_valid,
  output logic             aw_ready,
  input  logic [ID_W-1:0]  aw_id,
  input  logic             w_valid,
  output logic             w_ready,
  input  logic             w_last,
  input  logic [AGE_W-1:0] sel_age,
  output logic             b_valid,
  input  logic             b_ready,
  output logic [ID_W-1:0]  b_id,
  output logic [1:0]       b_resp
);
  localparam int CNT_W = $clog2(SLOTS + 1);

  logic [SLOTS-1:0] vld;
  logic [SLOTS-1:0] done;
  logic [ID_W-1:0]  ids  [SLOTS];
  logic [AGE_W-1:0] ages [SLOTS];
  logic [CNT_W-1:0] count;
  logic [AGE_W-1:0] b_slot;
  logic [ID_W-1:0]  b_id_q;

  logic             free_ok;
  logic [AGE_W-1:0] new_slot;
  logic             pend_ok;
  logic [AGE_W-1:0] pend_slot;
  logic [AGE_W-1:0] w_tgt;
  logic             pick_ok;
  logic [AGE_W-1:0] pick_slot;
  logic             aw_fire, w_fire, b_fire;

  wrs_free_find #(.N(SLOTS), .IW(AGE_W)) u_free (
    .busy (vld),
    .found(free_ok),
    .idx  (new_slot)
  );

  wrs_picker #(.N(SLOTS), .IDW(ID_W), .AW(AGE_W), .DEPTH(DEPTH)) u_pick (
    .vld  (vld),
    .done (done),
    .ids  (ids),
    .ages (ages),
    .sel  (sel_age),
    .ok   (pick_ok),
    .slot (pick_slot)
  );

  // oldest transaction still collecting data
  always_comb begin
    pend_ok   = 1'b0;
    pend_slot = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (vld[i] && !done[i] && (!pend_ok || ages[i] < ages[pend_slot])) begin
        pend_ok   = 1'b1;
        pend_slot = AGE_W'(i);
      end
    end
  end

  assign aw_ready = free_ok;
  assign aw_fire  = aw_valid && aw_ready;
  assign w_ready  = pend_ok || aw_fire;
  assign w_fire   = w_valid && w_ready;
  assign w_tgt    = pend_ok ? pend_slot : new_slot;
  assign b_fire   = b_valid && b_ready;
  assign b_id     = b_id_q;
  assign b_resp   = RESP_OKAY;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld     <= '0;
      done    <= '0;
      count   <= '0;
      b_valid <= 1'b0;
      b_slot  <= '0;
      b_id_q  <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (b_fire && vld[i] && ages[i] > ages[b_slot])
          ages[i] <= ages[i] - 1'b1;
      end
      if (b_fire) begin
        vld[b_slot]  <= 1'b0;
        done[b_slot] <= 1'b0;
        b_valid      <= 1'b0;
      end
      if (aw_fire) begin
        vld[new_slot]  <= 1'b1;
        done[new_slot] <= 1'b0;
        ids[new_slot]  <= aw_id;
        ages[new_slot] <= AGE_W'(count - CNT_W'(b_fire));
      end
      if (w_fire && w_last)
        done[w_tgt] <= 1'b1;
      count <= count + CNT_W'(aw_fire) - CNT_W'(b_fire);
      if (!b_valid && pick_ok) begin
        b_valid <= 1'b1;
        b_slot  <= pick_slot;
        b_id_q  <= ids[pick_slot];
      end
    end
  end

  // same-ID older entry still waiting behind the one being answered
  logic older_same_b;
  always_comb begin
    older_same_b = 1'b0;
    for (int j = 0; j < SLOTS; j++) begin
      if (vld[j] && AGE_W'(j) != b_slot && ids[j] == ids[b_slot] && ages[j] < ages[b_slot])
        older_same_b = 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    int'(count) <= SLOTS) else $error("outstanding count above limit"); // R1
  AST_W_HAS_ADDR: assert property (@(posedge clk) disable iff (rst)
    w_valid && w_ready |-> (count != '0) || aw_valid) else $error("data without address"); // R2
  AST_RESP_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    b_valid |-> vld[b_slot] && done[b_slot]) else $error("response before last beat"); // R3
  AST_ID_ORDER: assert property (@(posedge clk) disable iff (rst)
    b_valid |-> !older_same_b) else $error("same-ID order broken"); // R4
  AST_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    b_valid |-> int'(ages[b_slot]) < DEPTH) else $error("answer outside window"); // R6
  AST_B_STABLE: assert property (@(posedge clk) disable iff (rst)
    b_valid && !b_ready |=> b_valid && $stable(b_id)) else $error("B channel changed while stalled"); // R8
endmodule

// File: tb/wresp_sched_tb.sv
module wresp_sched_tb;
  localparam int SLOTS = 4;
  localparam int ID_W  = 4;
  localparam int DEPTH = 2;
  localparam int AGE_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic aw_valid = 1'b0, w_valid = 1'b0, w_last = 1'b0, b_ready = 1'b0;
  logic [ID_W-1:0]  aw_id = '0;
  logic [AGE_W-1:0] sel_age = '0;
  logic aw_ready, w_ready, b_valid;
  logic [ID_W-1:0] b_id;
  logic [1:0] b_resp;

  int checks = 0;
  int fails  = 0;
  int exp_q[$];
  int model[$];
  int pidx = 0;
  int pred = 0;

  always #10 clk = ~clk;

  wresp_sched #(.SLOTS(SLOTS), .ID_W(ID_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id),
    .w_valid(w_valid), .w_ready(w_ready), .w_last(w_last),
    .sel_age(sel_age),
    .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id), .b_resp(b_resp)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  // expected choice when every listed transaction has complete data
  function automatic int pick(input int s);
    if (s < model.size() && s < DEPTH) begin
      bit clash = 1'b0;
      for (int j = 0; j < s; j++) if (model[j] == model[s]) clash = 1'b1;
      if (!clash) return s;
    end
    return 0;
  endfunction

  task automatic prime();
    pidx = pick(int'(sel_age));
    pred = model[pidx];
  endtask

  task automatic send_aw(input int id);
    aw_valid = 1'b1;
    aw_id    = ID_W'(id);
    do @(negedge clk); while (!aw_ready);
    tick();
    aw_valid = 1'b0;
    model.push_back(id);
  endtask

  task automatic send_w(input bit last);
    w_valid = 1'b1;
    w_last  = last;
    do @(negedge clk); while (!w_ready);
    tick();
    w_valid = 1'b0;
    w_last  = 1'b0;
  endtask

  // driver: predict the held response, then choose the next selection
  task automatic step(input int s);
    while (!b_valid) tick();
    exp_q.push_back(pred);
    model.delete(pidx);
    sel_age = AGE_W'(s);
    if (model.size() > 0) prime();
    b_ready = 1'b1;
    tick();
    b_ready = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) tick();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // monitor: compare every B handshake against the scoreboard
  always @(negedge clk) begin
    if (!rst && b_valid && b_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4/R5 unexpected response", int'(b_id), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(int'(b_id) == e, "R4/R5/R6/R7 response order", int'(b_id), e);
        check(b_resp == 2'b00, "R8 resp OKAY", int'(b_resp), 0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    @(negedge clk);
    check(b_valid == 1'b0, "R10 b_valid after reset", int'(b_valid), 0);
    check(aw_ready == 1'b1, "R10 aw_ready after reset", int'(aw_ready), 1);
    check(w_ready == 1'b0, "R10 R2 w_ready with no address", int'(w_ready), 0);

    // R9: address and last beat together
    tick();
    aw_valid = 1'b1; aw_id = 4'd7; w_valid = 1'b1; w_last = 1'b1;
    @(negedge clk);
    check(w_ready == 1'b1, "R9 w_ready with same-cycle address", int'(w_ready), 1);
    tick();
    aw_valid = 1'b0; w_valid = 1'b0; w_last = 1'b0;
    model.push_back(7);
    sel_age = '0;
    prime();
    @(negedge clk);
    check(b_valid == 1'b0, "R9 b_valid one edge later", int'(b_valid), 0);
    tick();
    @(negedge clk);
    check(b_valid == 1'b1, "R9 b_valid two edges later", int'(b_valid), 1);
    tick();
    step(0);
    drain();

    // distinct IDs, multi-beat first transaction
    sel_age = '0;
    send_aw(1); send_aw(2); send_aw(3); send_aw(4);
    @(negedge clk);
    check(aw_ready == 1'b0, "R1 aw_ready low when full", int'(aw_ready), 0);
    tick();
    send_w(1'b0); send_w(1'b0);
    repeat (2) tick();
    @(negedge clk);
    check(b_valid == 1'b0, "R3 no response before last", int'(b_valid), 0);
    tick();
    send_w(1'b1); send_w(1'b1); send_w(1'b1); send_w(1'b1);
    repeat (3) tick();
    prime();
    begin
      logic [ID_W-1:0] held;
      held = b_id;
      repeat (3) tick();
      @(negedge clk);
      check(b_valid == 1'b1 && b_id == held, "R8 B held while stalled", int'(b_id), int'(held));
      tick();
    end
    step(1);   // R5: rank 1 requested
    step(2);   // R6: rank 2 outside window
    step(0);
    step(0);
    drain();

    // repeated IDs
    sel_age = '0;
    send_aw(5); send_aw(5); send_aw(6); send_aw(5);
    send_w(1'b1); send_w(1'b1); send_w(1'b1); send_w(1'b1);
    repeat (3) tick();
    prime();
    step(1);   // R5: other ID at rank 1
    step(1);   // R4 R7: same ID at rank 1, fallback
    step(1);   // R7: rank out of range
    step(0);
    drain();

    // window limit
    sel_age = '0;
    send_aw(8); send_aw(9); send_aw(10); send_aw(11);
    send_w(1'b1); send_w(1'b1); send_w(1'b1); send_w(1'b1);
    repeat (3) tick();
    prime();
    step(2);   // R6: rank 2 not in window, fallback to rank 0
    step(1);
    step(0);
    step(0);
    drain();
    repeat (3) tick();
    @(negedge clk);
    check(b_valid == 1'b0 && aw_ready == 1'b1, "R1 all slots free at end", int'(b_valid), 0);
    finish_run();
  end
endmodule